// File: doc/BRIEF.md
# Thermal Trip Interrupt Controller

The controller watches an 8-bit temperature code from a sensor front end and turns threshold crossings into latched interrupt status. One shared base threshold is programmed once; each of four trip levels adds its own 8-bit offset to it. When the temperature climbs past a level, that level's rising status bit latches. Once a level has tripped, its falling status bit latches when the temperature drops below the rising point minus a programmable hysteresis. Software sees all status in one register, clears it with write-one-to-clear, and receives a single registered interrupt line.

For bring-up and test, an emulation mode replaces the sensor with a software-written temperature. That value is loaded on a programmable sample interval, and the sensor input is ignored while the mode is on. A run bit makes the unit active or idle and can be read back.

Register map (word index on `reg_addr`): 0 control (bit0 run, bit1 emulation), 1 base threshold [7:0], 2 level offsets (level i in bits [8i+7:8i]), 3 hysteresis [7:0], 4 enables (rising [3:0], falling [7:4]), 5 status (rising [3:0], falling [7:4], read-only), 6 clear (write-one, same bit layout as status), 7 emulation (temperature [7:0], interval [23:8]), 8 temperature (current code [7:0], active flag bit 8). Reads are combinational.

Top module: `thermal_trip_irq`

## Requirements
- R1: After reset all status bits, the enables, the offsets, the hysteresis and `irq` are 0, the base threshold reads 80, the control register reads 0, and register 8 reads 0 (idle, temperature 0).
- R2: The trip point of level i is base + offset i (offset i in register 2 bits [8i+7:8i]), saturated at 255. Level i counts as crossed when the current temperature is strictly greater than its trip point.
- R3: A write to register 1 stores the value clamped to the range 25..125.
- R4: Rising bit i of register 4 enables level i. A level whose enable is 0 never sets its rising status bit (register 5 bit i).
- R5: A rising status bit sets only in the cycle after the temperature goes from not-crossed to crossed. It stays set until cleared, and it does not set again while the temperature stays above the trip point.
- R6: Falling status bit i (register 5 bit 4+i, enabled by register 4 bit 4+i) sets when the temperature falls below trip point i minus the hysteresis (floored at 0). This happens only once per rising event of level i, and only after that rising event.
- R7: Writing 1 to a bit of register 6 clears the matching status bit. When a new event arrives in the same cycle as its clear, the event wins and the bit stays set.
- R8: `irq` is a register that is high one cycle after any status bit with its enable set is pending, and low one cycle after none is.
- R9: While emulation and run are both on, the sensor input is ignored. The temperature register is loaded with the emulated value once every interval+1 cycles, counted from the cycle emulation is turned on.
- R10: Register 8 bit 8 mirrors the run bit. While idle, no sample (sensor or emulated) changes the temperature.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sens_valid | input | 1 | Sensor sample strobe |
| sens_temp | input | 8 | Sensor temperature code |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Registered interrupt |

## Verification
The two functions that can meet in one cycle are a fresh threshold crossing latching a status bit and a software write to the clear register that targets the same bit. The bench provokes this on purpose. It strobes a hot sample into the temperature register on one edge and presents the clear write so that it lands on the very next edge, where the rising event is evaluated. It then reads the status register and expects the bit to be set, because a new event must not be lost. A separate case clears a bit with no event pending, which shows that the clear itself works.

// File: rtl/thermal_trip_irq.sv
module thermal_trip_irq #(
  parameter int TW       = 8,
  parameter int NLVL     = 4,
  parameter int EW       = 16,
  parameter int AW       = 4,
  parameter int BASE_MIN = 25,
  parameter int BASE_MAX = 125,
  parameter int BASE_RST = 80
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sens_valid,
  input  logic [TW-1:0] sens_temp,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          irq
);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_BASE = AW'(1);
  localparam logic [AW-1:0] A_OFFS = AW'(2);
  localparam logic [AW-1:0] A_HYST = AW'(3);
  localparam logic [AW-1:0] A_EN   = AW'(4);
  localparam logic [AW-1:0] A_STAT = AW'(5);
  localparam logic [AW-1:0] A_CLR  = AW'(6);
  localparam logic [AW-1:0] A_EMUL = AW'(7);
  localparam logic [AW-1:0] A_TEMP = AW'(8);
  localparam logic [TW-1:0] T_MAX  = {TW{1'b1}};
  localparam logic [TW-1:0] B_MIN  = TW'(BASE_MIN);
  localparam logic [TW-1:0] B_MAX  = TW'(BASE_MAX);

  logic                     run, emul_on;
  logic [TW-1:0]            base, hyst, cur_temp, emul_temp;
  logic [NLVL-1:0][TW-1:0]  offs;
  logic [NLVL-1:0]          rise_en, fall_en, rise_st, fall_st, armed, hot_q;
  logic [EW-1:0]            emul_time, emul_cnt;
  logic [NLVL-1:0][TW-1:0]  rise_thr, fall_thr;
  logic [NLVL-1:0]          hot, cold, rise_evt, fall_evt, clr_r, clr_f;
  logic [TW-1:0]            wbase, base_in;

  wire wr_ctrl = reg_we && reg_addr == A_CTRL;
  wire wr_base = reg_we && reg_addr == A_BASE;
  wire wr_offs = reg_we && reg_addr == A_OFFS;
  wire wr_hyst = reg_we && reg_addr == A_HYST;
  wire wr_en   = reg_we && reg_addr == A_EN;
  wire wr_clr  = reg_we && reg_addr == A_CLR;
  wire wr_emul = reg_we && reg_addr == A_EMUL;

  assign wbase   = reg_wdata[TW-1:0];
  assign base_in = (wbase < B_MIN) ? B_MIN : (wbase > B_MAX) ? B_MAX : wbase;
  assign clr_r   = wr_clr ? reg_wdata[NLVL-1:0] : '0;
  assign clr_f   = wr_clr ? reg_wdata[2*NLVL-1:NLVL] : '0;

  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    wire [TW:0] sum = {1'b0, base} + {1'b0, offs[g]};
    assign rise_thr[g] = sum[TW] ? T_MAX : sum[TW-1:0];
    assign fall_thr[g] = (rise_thr[g] > hyst) ? rise_thr[g] - hyst : '0;
    assign hot[g]      = cur_temp > rise_thr[g];
    assign cold[g]     = cur_temp < fall_thr[g];
  end

  assign rise_evt = hot & ~hot_q & rise_en;
  assign fall_evt = armed & cold & fall_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run       <= 1'b0;
      emul_on   <= 1'b0;
      base      <= TW'(BASE_RST);
      offs      <= '0;
      hyst      <= '0;
      rise_en   <= '0;
      fall_en   <= '0;
      emul_temp <= '0;
      emul_time <= '0;
    end else begin
      if (wr_ctrl) {emul_on, run} <= reg_wdata[1:0];
      if (wr_base) base <= base_in;
      if (wr_offs) offs <= reg_wdata[NLVL*TW-1:0];
      if (wr_hyst) hyst <= reg_wdata[TW-1:0];
      if (wr_en)   {fall_en, rise_en} <= reg_wdata[2*NLVL-1:0];
      if (wr_emul) {emul_time, emul_temp} <= reg_wdata[TW+EW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_temp <= '0;
      emul_cnt <= '0;
    end else if (run && emul_on) begin
      if (emul_cnt >= emul_time) begin
        cur_temp <= emul_temp;
        emul_cnt <= '0;
      end else begin
        emul_cnt <= emul_cnt + 1'b1;
      end
    end else begin
      emul_cnt <= '0;
      if (run && sens_valid) cur_temp <= sens_temp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hot_q   <= '0;
      armed   <= '0;
      rise_st <= '0;
      fall_st <= '0;
      irq     <= 1'b0;
    end else begin
      hot_q   <= hot;
      armed   <= (armed & ~(armed & cold)) | rise_evt;
      rise_st <= (rise_st & ~clr_r) | rise_evt;
      fall_st <= (fall_st & ~clr_f) | fall_evt;
      irq     <= |((rise_st & rise_en) | (fall_st & fall_en));
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:  reg_rdata = 32'({emul_on, run});
      A_BASE:  reg_rdata = 32'(base);
      A_OFFS:  reg_rdata = 32'(offs);
      A_HYST:  reg_rdata = 32'(hyst);
      A_EN:    reg_rdata = 32'({fall_en, rise_en});
      A_STAT:  reg_rdata = 32'({fall_st, rise_st});
      A_EMUL:  reg_rdata = 32'({emul_time, emul_temp});
      A_TEMP:  reg_rdata = 32'({run, cur_temp});
      default: reg_rdata = '0;
    endcase
  end

  AST_BASE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    base >= B_MIN && base <= B_MAX); // R3

  AST_DISABLED_STAYS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_st & ~$past(rise_st) & ~$past(rise_en)) == '0); // R4

  AST_IRQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    ((rise_st & rise_en) == '0 && (fall_st & fall_en) == '0) |=> !irq); // R8

  AST_EMUL_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (run && emul_on && emul_cnt < emul_time) |=> $stable(cur_temp)); // R9

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cur_temp)); // R10

  for (genvar g = 0; g < NLVL; g++) begin : g_chk
    AST_RISE_ABOVE_BASE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rise_st[g]) |-> $past(cur_temp) > $past(base)); // R2

    AST_FALL_BELOW_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fall_st[g]) |-> $past(cur_temp) <= $past(rise_thr[g])); // R6

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_clr && reg_wdata[g] && !(hot[g] && !hot_q[g] && rise_en[g])) |=> !rise_st[g]); // R7
  end
endmodule

// File: tb/thermal_trip_irq_tb_top.sv
module thermal_trip_irq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sens_valid = 1'b0;
  logic [7:0]  sens_temp = '0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  thermal_trip_irq dut_i (
    .clk(clk), .rst_n(rst_n), .sens_valid(sens_valid), .sens_temp(sens_temp),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  // temp[15:8], expected rising[7:4], expected falling[3:0]; base 50, offsets 0/10/20/30, hysteresis 5
  localparam logic [15:0] VEC [0:8] = '{
    16'h28_00, 16'h32_00, 16'h33_10, 16'h41_30, 16'h55_F0,
    16'h4E_F0, 16'h4A_F8, 16'h3C_FC, 16'h28_FF
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic sample(input logic [7:0] t);
    @(negedge clk);
    sens_valid = 1'b1; sens_temp = t;
    @(negedge clk);
    sens_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(4'd5, d); chk("R1 status", d, 32'h0);
    rd(4'd1, d); chk("R1 base", d, 32'd80);
    rd(4'd8, d); chk("R1 idle temp", d, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    wr(4'd0, 32'h1);
    wr(4'd1, 32'd50);
    wr(4'd2, 32'h1E140A00);
    wr(4'd3, 32'd5);
    wr(4'd4, 32'hFF);

    for (int i = 0; i < 9; i++) begin
      sample(VEC[i][15:8]);
      rd(4'd5, d);
      chk("R2 R5 R6 vector", d, {24'b0, VEC[i][3:0], VEC[i][7:4]});
    end
    chk("R8 irq pending", {31'b0, irq}, 32'h1);

    wr(4'd6, 32'h01);
    rd(4'd5, d); chk("R7 partial clear", d, 32'hFE);
    wr(4'd6, 32'hFE);
    rd(4'd5, d); chk("R7 full clear", d, 32'h0);
    @(negedge clk);
    chk("R8 irq drops", {31'b0, irq}, 32'h0);

    sample(8'd55);
    rd(4'd5, d); chk("R5 cross sets", d, 32'h01);
    wr(4'd6, 32'h01);
    sample(8'd56);
    rd(4'd5, d); chk("R5 no re-set while hot", d, 32'h0);
    sample(8'd40);
    rd(4'd5, d); chk("R6 fall after rise", d, 32'h10);
    sample(8'd30);
    wr(4'd6, 32'hFF);
    sample(8'd20);
    rd(4'd5, d); chk("R6 one fall per rise", d, 32'h0);

    wr(4'd4, 32'hFE);
    sample(8'd55);
    rd(4'd5, d); chk("R4 disabled level", d, 32'h0);
    sample(8'd40);
    wr(4'd4, 32'hFF);
    wr(4'd6, 32'hFF);

    // clear lands on the same edge as the new rising event
    @(negedge clk);
    sens_valid = 1'b1; sens_temp = 8'd55;
    @(negedge clk);
    sens_valid = 1'b0;
    reg_we = 1'b1; reg_addr = 4'd6; reg_wdata = 32'h01;
    @(negedge clk);
    reg_we = 1'b0;
    rd(4'd5, d); chk("R7 set wins over clear", d, 32'h01);
    sample(8'd40);
    wr(4'd6, 32'hFF);

    wr(4'd1, 32'd10);
    rd(4'd1, d); chk("R3 clamp low", d, 32'd25);
    wr(4'd1, 32'd200);
    rd(4'd1, d); chk("R3 clamp high", d, 32'd125);

    wr(4'd2, 32'hC81E140A);
    wr(4'd6, 32'hFF);
    sample(8'd255);
    rd(4'd5, d); chk("R2 saturated trip", d, 32'h07);
    wr(4'd6, 32'hFF);

    wr(4'd7, {8'h0, 16'd10, 8'h5A});
    wr(4'd0, 32'h3);
    @(negedge clk);
    sens_valid = 1'b1; sens_temp = 8'd30;
    repeat (4) @(negedge clk);
    rd(4'd8, d); chk("R9 before interval", d, 32'h1FF);
    repeat (12) @(negedge clk);
    rd(4'd8, d); chk("R9 emulated value", d, 32'h15A);
    repeat (15) @(negedge clk);
    rd(4'd8, d); chk("R9 sensor ignored", d, 32'h15A);
    sens_valid = 1'b0;

    wr(4'd0, 32'h0);
    rd(4'd8, d); chk("R10 idle flag", d, 32'h05A);
    sample(8'd20);
    rd(4'd8, d); chk("R10 idle ignores sample", d, 32'h05A);
    wr(4'd0, 32'h1);
    sample(8'd20);
    rd(4'd8, d); chk("R10 active samples", d, 32'h114);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule